// File: doc/BRIEF.md
# Video-Memory Wait-State Controller with Operator Freeze

This block drives the active-low WAIT input of an 8-bit CPU. When the CPU asks for video memory while the video side is using it, the block pulls WAIT low so that the CPU stretches its bus cycle until the memory is free. The decision is captured in a flip-flop on the CPU clock, so WAIT answers one clock after the contention appears. While vertical blanking is active, video data moves by DMA and the CPU must never be stalled by the video side. The active-low blanking input therefore clears the wait flip-flop asynchronously for the whole interval.

A second source of WAIT is an operator freeze switch. The switch has two contacts, and each contact closes to ground. Each contact passes through a synchronizer. The contacts then drive a set/reset state that behaves like two cross-coupled NAND gates, so contact bounce cannot toggle it. While freeze is set, WAIT is held low indefinitely, even during blanking, and the machine halts mid-frame for inspection. A two-bit status output tells which source is holding WAIT low.

Top module: `vram_wait_ctrl`

## Requirements
- R1: With freeze clear and `vblank_n` high, `wait_n` goes low after a rising edge at which `vram_busy_n` and `vram_req_n` were both low. After an edge at which either of them was high, `wait_n` is high.
- R2: The contention condition is registered. A change of `vram_busy_n` or `vram_req_n` has no effect on `wait_n` before the next rising clock edge, and it shows on `wait_n` right after that edge.
- R3: `wait_n` stays low at every edge for as long as both `vram_busy_n` and `vram_req_n` stay low, and it returns high one edge after the condition ends.
- R4: While `vblank_n` is low, the contention flip-flop is cleared asynchronously. With freeze clear, `wait_n` goes high as soon as `vblank_n` falls, without waiting for a clock edge. When `vblank_n` returns high, contention is captured again at the next edge.
- R5: The freeze contacts are active low: `frz_set_n` is the freeze contact and `frz_clr_n` is the run contact. Freeze becomes set when only `frz_set_n` is low, and it becomes clear when only `frz_clr_n` is low. A contact change reaches `wait_n` at the third rising edge after the change: two synchronizer stages, then the latch.
- R6: When both contacts read open, or both read closed, the freeze state keeps its previous value. So bounce on either contact does not toggle freeze.
- R7: While freeze is set, `wait_n` is low whatever the values of `vblank_n`, `vram_busy_n` and `vram_req_n`.
- R8: A synchronous active-high `rst` clears the contention flip-flop, the synchronizers (to contacts open) and the freeze state. After a reset edge, `wait_n` is 1 and `wait_src` is 2'b00.
- R9: `wait_src` is 2'b00 when `wait_n` is high, 2'b10 when freeze holds WAIT (freeze wins over contention), and 2'b01 when only contention holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU/pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vram_busy_n | input | 1 | Video memory in use by the video side, active low |
| vram_req_n | input | 1 | CPU access to video memory, active low |
| vblank_n | input | 1 | Vertical blanking, active low; asynchronous clear of the wait flip-flop |
| frz_set_n | input | 1 | Freeze switch contact, closed = low |
| frz_clr_n | input | 1 | Run switch contact, closed = low |
| wait_n | output | 1 | WAIT to the CPU, active low |
| wait_src | output | 2 | Source of WAIT: 00 none, 01 contention, 10 freeze |

## Verification
The checker tests these properties on every cycle:
- a registered contention condition gives WAIT low one edge later, and its absence gives WAIT high;
- blanking forces WAIT to follow only the freeze state;
- freeze always holds WAIT low;
- the freeze state is unchanged after an edge at which the synchronized contacts agreed;
- the status code matches WAIT.

Some behaviours only the bench scenarios can show:
- the release on a falling `vblank_n` with no clock edge;
- the three-edge delay from a contact change to WAIT;
- the fact that WAIT moves only once during injected bounce trains on either contact.

// File: rtl/vwc_pkg.sv
package vwc_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_MEM  = 2'b01,
        SRC_FRZ  = 2'b10
    } wait_src_e;

    typedef struct packed {
        logic set_n;
        logic clr_n;
    } spdt_t;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_SET,
        CMD_CLR
    } latch_cmd_e;

    localparam spdt_t CONTACTS_OPEN = '{set_n: 1'b1, clr_n: 1'b1};

    // One contact closed alone moves the latch; agreement keeps it.
    function automatic latch_cmd_e decode_contacts(spdt_t c);
        latch_cmd_e cmd;
        if (!c.set_n && c.clr_n)
            cmd = CMD_SET;
        else if (c.set_n && !c.clr_n)
            cmd = CMD_CLR;
        else
            cmd = CMD_HOLD;
        return cmd;
    endfunction

    function automatic wait_src_e classify(logic mem_hold, logic frz_hold);
        wait_src_e s;
        if (frz_hold)
            s = SRC_FRZ;
        else if (mem_hold)
            s = SRC_MEM;
        else
            s = SRC_NONE;
        return s;
    endfunction

endpackage

// File: rtl/vwc_sync.sv
module vwc_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= RST_VAL;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= RST_VAL;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/vwc_freeze_latch.sv
module vwc_freeze_latch
    import vwc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  spdt_t contacts,
    output logic  frozen
);
    latch_cmd_e cmd;
    logic       state_q;

    always_comb cmd = decode_contacts(contacts);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_SET:  state_q <= 1'b1;
                CMD_CLR:  state_q <= 1'b0;
                default:  state_q <= state_q;
            endcase
        end
    end

    assign frozen = state_q;
endmodule

// File: rtl/vwc_contention_ff.sv
module vwc_contention_ff (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic busy_n,
    input  logic req_n,
    output logic hold
);
    logic clash;

    always_comb clash = ~busy_n & ~req_n;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)   hold <= 1'b0;
        else if (rst) hold <= 1'b0;
        else          hold <= clash;
    end
endmodule

// File: rtl/vram_wait_ctrl.sv
module vram_wait_ctrl
    import vwc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vram_busy_n,
    input  logic       vram_req_n,
    input  logic       vblank_n,
    input  logic       frz_set_n,
    input  logic       frz_clr_n,
    output logic       wait_n,
    output logic [1:0] wait_src
);
    localparam int CONTACT_W = $bits(spdt_t);

    spdt_t     contacts_raw;
    spdt_t     contacts_sync;
    logic      mem_hold;
    logic      frz_active;
    wait_src_e src;

    always_comb begin
        contacts_raw.set_n = frz_set_n;
        contacts_raw.clr_n = frz_clr_n;
    end

    vwc_sync #(
        .WIDTH  (CONTACT_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CONTACTS_OPEN)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (contacts_raw),
        .q  (contacts_sync)
    );

    vwc_freeze_latch i_frz (
        .clk     (clk),
        .rst     (rst),
        .contacts(contacts_sync),
        .frozen  (frz_active)
    );

    vwc_contention_ff i_cont (
        .clk   (clk),
        .rst   (rst),
        .clr_n (vblank_n),
        .busy_n(vram_busy_n),
        .req_n (vram_req_n),
        .hold  (mem_hold)
    );

    always_comb begin
        src      = classify(mem_hold, frz_active);
        wait_n   = ~(mem_hold | frz_active);
        wait_src = src;
    end
endmodule

// File: rtl/vwc_checker.sv
module vwc_checker
    import vwc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       vram_busy_n,
    input logic       vram_req_n,
    input logic       vblank_n,
    input logic       wait_n,
    input logic [1:0] wait_src,
    input logic       frz_q,
    input spdt_t      frz_sync
);
    AST_CLASH_WAITS: assert property (@(posedge clk) disable iff (rst)
        (vblank_n && $past(vblank_n) && !$past(rst) && $past(!vram_busy_n && !vram_req_n)) |-> !wait_n); // R2

    AST_NO_CLASH_RUNS: assert property (@(posedge clk) disable iff (rst)
        ($past(vram_busy_n || vram_req_n) && !frz_q) |-> wait_n); // R1

    AST_BLANK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !vblank_n |-> (wait_n == !frz_q)); // R4

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        frz_q |-> !wait_n); // R7

    AST_AGREE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (frz_sync.set_n == frz_sync.clr_n) |=> (frz_q == $past(frz_q))); // R6

    AST_RESET_RUNS: assert property (@(posedge clk)
        $past(rst) |-> (wait_n && wait_src == SRC_NONE)); // R8

    AST_SRC_MATCHES: assert property (@(posedge clk) disable iff (rst)
        (wait_n == (wait_src == SRC_NONE)) && (frz_q == (wait_src == SRC_FRZ))); // R9
endmodule

bind vram_wait_ctrl vwc_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .vram_busy_n(vram_busy_n),
    .vram_req_n (vram_req_n),
    .vblank_n   (vblank_n),
    .wait_n     (wait_n),
    .wait_src   (wait_src),
    .frz_q      (frz_active),
    .frz_sync   (contacts_sync)
);

// File: tb/test_vram_wait_ctrl.sv
module test_vram_wait_ctrl;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       busy_n, req_n, vb_n, set_n, clr_n;
    logic       wait_n;
    logic [1:0] wait_src;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #(PERIOD/2) clk = ~clk;

    vram_wait_ctrl i_vram_wait_ctrl (
        .clk(clk), .rst(rst), .vram_busy_n(busy_n), .vram_req_n(req_n),
        .vblank_n(vb_n), .frz_set_n(set_n), .frz_clr_n(clr_n),
        .wait_n(wait_n), .wait_src(wait_src)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; busy_n = 1; req_n = 1; vb_n = 1; set_n = 1; clr_n = 0;
        cyc(3);
        chk("R8 reset wait_n", wait_n, 1);
        chk("R8 reset src", wait_src, 0);
        rst = 0;
        cyc(4);

        // R1 / R9: sweep every busy/req/blank combination
        for (int i = 0; i < 8; i++) begin
            busy_n = i[0]; req_n = i[1]; vb_n = i[2];
            cyc(1);
            chk("R1 sweep wait_n", wait_n, (!busy_n && !req_n && vb_n) ? 0 : 1);
            chk("R9 sweep src", wait_src, (!busy_n && !req_n && vb_n) ? 1 : 0);
        end

        // R2: one-edge latency
        busy_n = 1; req_n = 1; vb_n = 1;
        cyc(1);
        busy_n = 0; req_n = 0;
        #1 chk("R2 no combinational path", wait_n, 1);
        cyc(1);
        chk("R2 low after one edge", wait_n, 0);

        // R3: hold while the condition lasts
        for (int k = 0; k < 20; k++) begin
            cyc(1);
            chk("R3 hold", wait_n, 0);
        end
        req_n = 1;
        #1 chk("R3 still low before edge", wait_n, 0);
        cyc(1);
        chk("R3 release after edge", wait_n, 1);

        // R4: asynchronous release on blanking
        req_n = 0;
        cyc(1);
        chk("R4 pre blank", wait_n, 0);
        vb_n = 0;
        #1 chk("R4 immediate release", wait_n, 1);
        for (int k = 0; k < 5; k++) begin
            cyc(1);
            chk("R4 held clear", wait_n, 1);
        end
        vb_n = 1;
        cyc(1);
        chk("R4 recapture", wait_n, 0);
        busy_n = 1; req_n = 1;
        cyc(1);

        // R6: both contacts open keeps the clear state
        clr_n = 1;
        for (int k = 0; k < 5; k++) begin
            cyc(1);
            chk("R6 both open hold clear", wait_n, 1);
        end

        // R6 / R5: bounce on the freeze contact, WAIT falls only once
        begin
            bit seen_low = 0;
            logic [11:0] pat = 12'b0000_0010_1101;
            for (int k = 0; k < 12; k++) begin
                set_n = pat[k];
                cyc(1);
                if (seen_low) chk("R6 no toggle on set bounce", wait_n, 0);
                if (!wait_n) seen_low = 1;
            end
        end
        set_n = 0;
        cyc(4);
        chk("R5 frozen", wait_n, 0);
        chk("R9 freeze src", wait_src, 2);

        // R6: freeze kept with contacts open, then R5 exact delay on release
        set_n = 1;
        for (int k = 0; k < 4; k++) begin
            cyc(1);
            chk("R6 both open hold set", wait_n, 0);
        end
        clr_n = 0;
        cyc(1); chk("R5 edge1", wait_n, 0);
        cyc(1); chk("R5 edge2", wait_n, 0);
        cyc(1); chk("R5 edge3", wait_n, 1);

        // re-freeze and test priority over blanking and contention
        clr_n = 1; set_n = 0;
        cyc(1); chk("R5 set edge1", wait_n, 1);
        cyc(1); chk("R5 set edge2", wait_n, 1);
        cyc(1); chk("R5 set edge3", wait_n, 0);
        vb_n = 0;
        #1 chk("R7 freeze over blank", wait_n, 0);
        cyc(3);
        chk("R7 freeze during blank", wait_n, 0);
        vb_n = 1; busy_n = 0; req_n = 0;
        cyc(2);
        chk("R9 freeze wins src", wait_src, 2);
        busy_n = 1; req_n = 1;

        // R6: both contacts closed keeps the state
        clr_n = 0;
        for (int k = 0; k < 6; k++) begin
            cyc(1);
            chk("R6 both closed hold", wait_n, 0);
        end

        // R6: bounce on the run contact, WAIT rises only once
        set_n = 1;
        begin
            bit seen_high = 0;
            logic [11:0] pat = 12'b1111_0101_1000;
            for (int k = 0; k < 12; k++) begin
                clr_n = pat[k];
                cyc(1);
                if (seen_high) chk("R6 no toggle on clr bounce", wait_n, 1);
                if (wait_n) seen_high = 1;
            end
        end
        clr_n = 0;
        cyc(4);
        chk("R5 released", wait_n, 1);

        // R8: reset while frozen
        clr_n = 1; set_n = 0;
        cyc(4);
        chk("R8 frozen before reset", wait_n, 0);
        rst = 1;
        cyc(1);
        chk("R8 reset clears wait", wait_n, 1);
        chk("R8 reset clears src", wait_src, 0);
        rst = 0;
        cyc(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule